// File: doc/BRIEF.md
# Configurable GPIO Register Bank

This block gives a set of general-purpose I/O lines a small register window on a word-addressed bus. Software reads the sampled pin levels through a data register, moves output levels either through that same register or through a bit-set / bit-clear pair, and chooses per-line drive direction through a direction register whose polarity is a build option. Every register except the data register can be left out at elaboration. A window built with only the data register is legal.

The pad side has three parts. Output values and output enables go out to the pads, and pad levels come in through a two-flop synchronizer. A line-count parameter confines all activity to the lowest lines. A sense-only option removes every output enable, so the block only watches its pins.

Top module: `gpio_regbank`

## Requirements
- R1: Bit n of every register and pad vector is line n. Lines at or above LINE_COUNT never drive (pad_out and pad_oe stay 0), read as 0, and ignore writes.
- R2: The data register (word 0) returns pad levels after two synchronizer flops. A pad value held before clock edge k is returned by a read issued at edge k+2.
- R3: bus_rdata is registered. It takes the addressed value at the edge where bus_re is 1 and holds otherwise. A write and a read in the same cycle return the value from before the write.
- R4: With both set (word 1) and clear (word 2) present, each 1 written to set drives its line high and each 1 written to clear drives its line low. Bits written as 0 leave their lines unchanged. The result shows on pad_out one cycle after the write.
- R5: With a set register but no clear register, a write to set loads pad_out with the written value, so 0 bits drive low.
- R6: Without a set register, a write to word 0 loads pad_out. When a set register exists, writes to word 0 leave pad_out unchanged. Outputs change only on a write.
- R7: With the output-high direction option, a write to word 3 makes pad_oe equal to the written bits, and pad_oe changes only after such a write.
- R8: With the input-high direction option, a write to word 3 makes pad_oe the inverse of the written bits on usable lines.
- R9: Without a direction register, every usable line is enabled from the first cycle after reset.
- R10: In sense-only mode, pad_oe is 0 on every line whatever is written.
- R11: A read of an absent register returns 0, and a write to it changes nothing.
- R12: During reset, pad_out, pad_oe and bus_rdata are all 0, and a direction-register build starts with every line as an input.
- R13: Words 1 and 2 read back the current output values. Word 3 reads back the direction in its own written polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Word address: 0 data, 1 set, 2 clear, 3 direction |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | W | Registered read data |
| pad_in | input | W | Pad levels, asynchronous |
| pad_out | output | W | Output value per line |
| pad_oe | output | W | Output enable per line |

## Verification
A bus write and a bus read can land in the same cycle, and both can target the same word. The bench provokes this in two ways. It drives random strobes on both, and it also issues a directed set-write that carries a read of the set word in the same cycle. The read data must return the output value from before the write, and the written value must appear one read later. Four builds are checked cycle by cycle against a behavioural model that holds its own value history, so every collision is judged on every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int ADDR_W = 2;
   typedef enum logic [ADDR_W-1:0] {
      REG_DATA = 2'd0,
      REG_SET  = 2'd1,
      REG_CLR  = 2'd2,
      REG_DIR  = 2'd3
   } gpio_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else if (s == 0) stg[s] <= d;
            else stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_drive_regs.sv
module gpio_drive_regs
   import gpio_pkg::*;
#(
   parameter int           W           = 32,
   parameter logic [W-1:0] MASK        = '1,
   parameter bit           HAS_SET     = 1'b1,
   parameter bit           HAS_CLR     = 1'b1,
   parameter bit           HAS_DIR     = 1'b1,
   parameter bit           DIR_IN_HIGH = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  gpio_reg_e    addr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] out_q,
   output logic [W-1:0] dir_en
);
   logic [W-1:0] wmask;
   assign wmask = wdata & MASK;

   generate
      if (!HAS_SET) begin : g_out_data
         always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else if (we && addr == REG_DATA) out_q <= wmask;
         end
      end else if (HAS_CLR) begin : g_out_setclr
         always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else if (we && addr == REG_SET) out_q <= out_q | wmask;
            else if (we && addr == REG_CLR) out_q <= out_q & ~wmask;
         end
      end else begin : g_out_setload
         always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else if (we && addr == REG_SET) out_q <= wmask;
         end
      end

      if (HAS_DIR) begin : g_dir_reg
         logic [W-1:0] en_next;
         assign en_next = (DIR_IN_HIGH ? ~wdata : wdata) & MASK;
         always_ff @(posedge clk) begin
            if (!rst_n) dir_en <= '0;
            else if (we && addr == REG_DIR) dir_en <= en_next;
         end
      end else begin : g_dir_fixed
         always_ff @(posedge clk) begin
            if (!rst_n) dir_en <= '0;
            else dir_en <= MASK;
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
   import gpio_pkg::*;
#(
   parameter int           W           = 32,
   parameter logic [W-1:0] MASK        = '1,
   parameter bit           HAS_SET     = 1'b1,
   parameter bit           HAS_CLR     = 1'b1,
   parameter bit           HAS_DIR     = 1'b1,
   parameter bit           DIR_IN_HIGH = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         re,
   input  gpio_reg_e    addr,
   input  logic [W-1:0] in_lvl,
   input  logic [W-1:0] out_q,
   input  logic [W-1:0] dir_en,
   output logic [W-1:0] rdata
);
   logic [W-1:0] sel;

   always_comb begin
      sel = '0;
      case (addr)
         REG_DATA: sel = in_lvl;
         REG_SET:  sel = HAS_SET ? out_q : '0;
         REG_CLR:  sel = HAS_CLR ? out_q : '0;
         REG_DIR:  sel = !HAS_DIR ? '0 : (DIR_IN_HIGH ? (~dir_en & MASK) : dir_en);
         default:  sel = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else if (re) rdata <= sel;
   end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_pkg::*;
#(
   parameter int W           = 32,
   parameter int LINE_COUNT  = 32,
   parameter bit HAS_SET     = 1'b1,
   parameter bit HAS_CLR     = 1'b1,
   parameter bit HAS_DIR     = 1'b1,
   parameter bit DIR_IN_HIGH = 1'b0,
   parameter bit NO_DRIVE    = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic             bus_we,
   input  logic [W-1:0]     bus_wdata,
   input  logic             bus_re,
   output logic [W-1:0]     bus_rdata,
   input  logic [W-1:0]     pad_in,
   output logic [W-1:0]     pad_out,
   output logic [W-1:0]     pad_oe
);
   localparam logic [W-1:0] LINE_MASK = {W{1'b1}} >> (W - LINE_COUNT);

   generate
      if (W < 1 || W > 64) begin : g_bad_width
         $error("gpio_regbank: W must be 1..64");
      end
      if (LINE_COUNT < 1 || LINE_COUNT > 63 || LINE_COUNT > W) begin : g_bad_lines
         $error("gpio_regbank: LINE_COUNT must be 1..63 and not above W");
      end
      if (HAS_CLR && !HAS_SET) begin : g_bad_clr
         $error("gpio_regbank: a clear register needs a set register");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_regbank: SYNC_STAGES must be at least 2");
      end
   endgenerate

   gpio_reg_e    addr_e;
   logic [W-1:0] in_lvl;
   logic [W-1:0] out_q;
   logic [W-1:0] dir_en;

   assign addr_e = gpio_reg_e'(bus_addr);

   gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in & LINE_MASK),
      .q     (in_lvl)
   );

   gpio_drive_regs #(
      .W(W), .MASK(LINE_MASK), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR),
      .HAS_DIR(HAS_DIR), .DIR_IN_HIGH(DIR_IN_HIGH)
   ) u_drive (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_we),
      .addr   (addr_e),
      .wdata  (bus_wdata),
      .out_q  (out_q),
      .dir_en (dir_en)
   );

   gpio_read_mux #(
      .W(W), .MASK(LINE_MASK), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR),
      .HAS_DIR(HAS_DIR), .DIR_IN_HIGH(DIR_IN_HIGH)
   ) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .re     (bus_re),
      .addr   (addr_e),
      .in_lvl (in_lvl),
      .out_q  (out_q),
      .dir_en (dir_en),
      .rdata  (bus_rdata)
   );

   assign pad_out = out_q;

   generate
      if (NO_DRIVE) begin : g_sense_only
         assign pad_oe = '0;
      end else begin : g_drive
         assign pad_oe = dir_en;
      end
   endgenerate
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
   parameter int W           = 32,
   parameter int LINE_COUNT  = 32,
   parameter bit HAS_SET     = 1'b1,
   parameter bit HAS_CLR     = 1'b1,
   parameter bit HAS_DIR     = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   bus_addr,
   input logic         bus_we,
   input logic [W-1:0] bus_wdata,
   input logic         bus_re,
   input logic [W-1:0] bus_rdata,
   input logic [W-1:0] pad_out,
   input logic [W-1:0] pad_oe
);
   localparam logic [W-1:0] LMASK = {W{1'b1}} >> (W - LINE_COUNT);

   function automatic logic absent(input logic [1:0] a);
      return (a == 2'd1 && !HAS_SET) || (a == 2'd2 && !HAS_CLR) || (a == 2'd3 && !HAS_DIR);
   endfunction

   assert_lines_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out | pad_oe) & ~LMASK) == '0);

   assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(bus_re)) |-> $stable(bus_rdata));

   assert_absent_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(bus_re) && absent($past(bus_addr))) |-> bus_rdata == '0);

   assert_clear_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_SET && HAS_CLR && $past(rst_n) && $past(bus_we) && $past(bus_addr) == 2'd2)
      |-> (pad_out & $past(bus_wdata)) == '0);

   assert_oe_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_DIR && $past(rst_n) && !($past(bus_we) && $past(bus_addr) == 2'd3))
      |-> $stable(pad_oe));

   assert_out_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(bus_we)) |-> $stable(pad_out));
endmodule

bind gpio_regbank gpio_regbank_chk #(
   .W(W), .LINE_COUNT(LINE_COUNT), .HAS_SET(HAS_SET), .HAS_CLR(HAS_CLR), .HAS_DIR(HAS_DIR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
   .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/tb_gpio_model.sv
module tb_gpio_model #(
   parameter int W           = 16,
   parameter int LINES       = 12,
   parameter bit HAS_SET     = 1'b1,
   parameter bit HAS_CLR     = 1'b1,
   parameter bit HAS_DIR     = 1'b1,
   parameter bit DIR_IN_HIGH = 1'b0,
   parameter bit NO_DRIVE    = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   addr,
   input  logic         we,
   input  logic         re,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pad,
   output logic [W-1:0] m_rdata,
   output logic [W-1:0] m_out,
   output logic [W-1:0] m_oe
);
   logic [W-1:0] usable;
   logic [W-1:0] en;
   logic [W-1:0] hist [$];
   logic [W-1:0] lvl;
   logic [W-1:0] rd;

   initial begin
      for (int i = 0; i < W; i++) usable[i] = (i < LINES);
      m_rdata = '0; m_out = '0; m_oe = '0; en = '0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rdata = '0; m_out = '0; en = '0;
         hist.delete();
      end else begin
         lvl = (hist.size() >= 2) ? hist[hist.size()-2] : '0;
         hist.push_back(pad & usable);
         if (hist.size() > 3) void'(hist.pop_front());
         case (addr)
            2'd0: rd = lvl;
            2'd1: rd = HAS_SET ? m_out : '0;
            2'd2: rd = HAS_CLR ? m_out : '0;
            default: rd = HAS_DIR ? (DIR_IN_HIGH ? (~en & usable) : en) : '0;
         endcase
         if (re) m_rdata = rd;
         if (we) begin
            if (addr == 2'd0 && !HAS_SET) m_out = wdata & usable;
            if (addr == 2'd1 && HAS_SET) begin
               if (HAS_CLR) m_out = m_out | (wdata & usable);
               else m_out = wdata & usable;
            end
            if (addr == 2'd2 && HAS_CLR) m_out = m_out & ~wdata;
            if (addr == 2'd3 && HAS_DIR) en = (DIR_IN_HIGH ? ~wdata : wdata) & usable;
         end
         if (!HAS_DIR) en = usable;
      end
      m_oe = NO_DRIVE ? '0 : en;
   end
endmodule

// File: tb/tb_gpio_regbank.sv
module tb_gpio_regbank;
   localparam int W = 16;
   localparam int LINES = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic we = 1'b0, re = 1'b0;
   logic [W-1:0] wdata = '0, pad = '0;
   int vectors = 0, fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   logic [W-1:0] r0, o0, e0, r1, o1, e1, r2, o2, e2, r3, o3, e3;
   logic [W-1:0] mr0, mo0, me0, mr1, mo1, me1, mr2, mo2, me2, mr3, mo3, me3;

   // full map, output-high direction
   gpio_regbank #(.W(W), .LINE_COUNT(LINES)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_re(re), .bus_rdata(r0), .pad_in(pad), .pad_out(o0), .pad_oe(e0));
   tb_gpio_model #(.W(W), .LINES(LINES)) m0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .re(re), .wdata(wdata), .pad(pad),
      .m_rdata(mr0), .m_out(mo0), .m_oe(me0));

   // set without clear, input-high direction
   gpio_regbank #(.W(W), .LINE_COUNT(LINES), .HAS_CLR(1'b0), .DIR_IN_HIGH(1'b1)) dut_setload (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_re(re), .bus_rdata(r1), .pad_in(pad), .pad_out(o1), .pad_oe(e1));
   tb_gpio_model #(.W(W), .LINES(LINES), .HAS_CLR(1'b0), .DIR_IN_HIGH(1'b1)) m1 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .re(re), .wdata(wdata), .pad(pad),
      .m_rdata(mr1), .m_out(mo1), .m_oe(me1));

   // data register only, always driving
   gpio_regbank #(.W(W), .LINE_COUNT(LINES), .HAS_SET(1'b0), .HAS_CLR(1'b0), .HAS_DIR(1'b0)) dut_data (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_re(re), .bus_rdata(r2), .pad_in(pad), .pad_out(o2), .pad_oe(e2));
   tb_gpio_model #(.W(W), .LINES(LINES), .HAS_SET(1'b0), .HAS_CLR(1'b0), .HAS_DIR(1'b0)) m2 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .re(re), .wdata(wdata), .pad(pad),
      .m_rdata(mr2), .m_out(mo2), .m_oe(me2));

   // data register only, sense-only
   gpio_regbank #(.W(W), .LINE_COUNT(LINES), .HAS_SET(1'b0), .HAS_CLR(1'b0), .HAS_DIR(1'b0),
                  .NO_DRIVE(1'b1)) dut_sense (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_re(re), .bus_rdata(r3), .pad_in(pad), .pad_out(o3), .pad_oe(e3));
   tb_gpio_model #(.W(W), .LINES(LINES), .HAS_SET(1'b0), .HAS_CLR(1'b0), .HAS_DIR(1'b0),
                   .NO_DRIVE(1'b1)) m3 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .re(re), .wdata(wdata), .pad(pad),
      .m_rdata(mr3), .m_out(mo3), .m_oe(me3));

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   // per-clock comparison against the models
   always @(negedge clk) begin
      if (!done) begin
         check("R13 full rdata", r0, mr0);
         check("R4 full pad_out", o0, mo0);
         check("R7 full pad_oe", e0, me0);
         check("R2 setload rdata", r1, mr1);
         check("R5 setload pad_out", o1, mo1);
         check("R8 setload pad_oe", e1, me1);
         check("R11 data rdata", r2, mr2);
         check("R6 data pad_out", o2, mo2);
         check("R9 data pad_oe", e2, me2);
         check("R2 sense rdata", r3, mr3);
         check("R6 sense pad_out", o3, mo3);
         check("R10 sense pad_oe", e3, me3);
      end
   end

   task automatic drive(input logic w, input logic r, input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      we = w; re = r; addr = a; wdata = d;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: state while reset is held
      check("R12 reset pad_out", o0, '0);
      check("R12 reset pad_oe", e0, '0);
      check("R12 reset rdata", r0, '0);
      check("R12 reset oe no-dir", e2, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 outputs after reset", o0, '0);
      check("R9 enables after reset", e2, 16'h0FFF);

      // R1: upper lines never drive, never read
      drive(1'b1, 1'b0, 2'd1, 16'hFFFF);
      drive(1'b1, 1'b0, 2'd3, 16'hFFFF);
      check("R1 pad_out masked", o0, 16'h0FFF);
      pad = 16'hFFFF;
      drive(1'b0, 1'b0, 2'd0, '0);
      check("R1 pad_oe masked", e0, 16'h0FFF);
      drive(1'b0, 1'b0, 2'd0, '0);
      drive(1'b0, 1'b1, 2'd0, '0);
      drive(1'b0, 1'b0, 2'd0, '0);
      check("R1 data read masked", r0, 16'h0FFF);

      // R3: write and read of the same word in one cycle
      drive(1'b1, 1'b0, 2'd2, 16'hFFFF);
      drive(1'b1, 1'b1, 2'd1, 16'h0005);
      drive(1'b0, 1'b1, 2'd1, '0);
      check("R3 same-cycle read sees old", r0, 16'h0000);
      drive(1'b0, 1'b0, 2'd0, '0);
      check("R3 later read sees new", r0, 16'h0005);

      // R8: input-high polarity
      drive(1'b1, 1'b0, 2'd3, 16'h00F0);
      drive(1'b0, 1'b0, 2'd0, '0);
      check("R8 inverted enables", e1, 16'h0F0F);

      // random traffic, both strobes may collide on one word
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         we = $urandom_range(0, 1);
         re = $urandom_range(0, 1);
         addr = 2'($urandom_range(0, 3));
         wdata = 16'($urandom);
         if ($urandom_range(0, 3) == 0) pad = 16'($urandom);
         if (i == 1500) rst_n = 1'b0;
         if (i == 1504) rst_n = 1'b1;
      end
      drive(1'b0, 1'b0, 2'd0, '0);
      @(negedge clk);
      finish_run();
   end
endmodule